// File: doc/BRIEF.md
# Latchable Parity Transceiver

This block joins two 9-bit ports, A and B, each carrying an 8-bit data field in bits [7:0] and a parity bit in bit 8. Words travel from A to B and from B to A through two separate transparent holding stages. Each stage has its own enable. While its enable is high, the stage passes its input straight through in the same cycle. While its enable is low, it keeps the word captured at the last rising clock edge at which the enable was high.

In each direction, the outgoing parity bit is either copied from the incoming word or replaced with a new bit computed from the 8 data bits. One select input sets odd or even parity for every generated bit and every check. Each port has its own error flag, which reports whether the word held for that port's incoming direction breaks the selected parity. The checks on the incoming side run while parity is generated on the outgoing side. The pads are split into input, output and output-enable signals. A direction input and an active-low output enable decide which port drives.

Top module: `par_xcvr`

## Requirements
- R1: While `le_ab` is high, `b_out` equals `a_in` in the same cycle when `gen_ab` is low. While `le_ba` is high, `a_out` equals `b_in` in the same cycle when `gen_ba` is low. Bit 8 is the parity bit and bits [7:0] are data.
- R2: While a direction's enable is low, its output data keeps the word sampled at the last rising clock edge at which that enable was high. Changes on the input have no effect.
- R3: The two holding stages are independent. Toggling `le_ba` or changing `b_in` leaves `b_out` unchanged, and the reverse holds for `a_out`.
- R4: With `gen_ab` high, `b_out[8]` is the XOR of the 8 held data bits, XORed with `par_odd` (0 selects even parity, 1 selects odd parity). `gen_ba` does the same for `a_out[8]`. The output data bits are the held data bits.
- R5: With the generate control of a direction low, the outgoing bit 8 equals bit 8 of the held incoming word.
- R6: `err_a` is high exactly when the XOR of the 9 held bits from port A differs from `par_odd`. `err_b` is high exactly when the same holds for the word held from port B.
- R7: Each error flag depends only on the held incoming word and `par_odd`, not on the generate control. Checking and generation work at the same time.
- R8: With `oe_n` low, `dir_a2b` high asserts `b_oe` and deasserts `a_oe`, and `dir_a2b` low does the reverse. With `oe_n` high, both are low.
- R9: While `rst_n` is low, both held words are zero. With the enables low and even parity, both outputs are zero and both error flags are low. The internal reset is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the holding registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a2b | input | 1 | 1: port B drives, 0: port A drives |
| oe_n | input | 1 | Active-low output enable |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| le_ab | input | 1 | Transparency enable, A to B |
| le_ba | input | 1 | Transparency enable, B to A |
| gen_ab | input | 1 | 1: generate parity toward B, 0: copy |
| gen_ba | input | 1 | 1: generate parity toward A, 0: copy |
| a_in | input | 9 | Word received on port A |
| a_out | output | 9 | Word presented on port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 9 | Word received on port B |
| b_out | output | 9 | Word presented on port B |
| b_oe | output | 1 | Drive enable for port B |
| err_a | output | 1 | Parity error on the word from A |
| err_b | output | 1 | Parity error on the word from B |

## Verification
On every cycle, the assertions check the following:
- only one port drives at a time, and neither drives when output enable is off;
- an output copies its input while transparent in copy mode;
- an output stays stable while its enable stays low;
- a generated word always satisfies the selected parity;
- in copy mode, each error flag agrees with the parity of the opposite output.

Some behaviour only the bench's directed scenarios can show. These are the exact value kept after an enable falls, the isolation between the two directions, the reset values and the two-edge reset release. The full matrix of direction, mode and parity select against an independent parity model is also covered only by the bench.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = DATA_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  // parity bit that makes the full word meet the chosen sense
  function automatic logic make_par(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // high when a full word breaks the chosen sense
  function automatic logic bad_word(input word_t w, input logic odd);
    return (^w) ^ odd;
  endfunction
endpackage

// File: rtl/par_xcvr_rst_sync.sv
module par_xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/par_xcvr_latch.sv
module par_xcvr_latch #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  // next-state: capture while enabled
  always_comb begin
    hold_d = hold_q;
    if (le) hold_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // transparent bypass while enabled, held word otherwise
  assign q = le ? d : hold_q;
endmodule

// File: rtl/par_xcvr_path.sv
module par_xcvr_path
  import par_xcvr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  le,
  input  logic  gen,
  input  logic  par_odd,
  input  word_t din,
  output word_t dout,
  output logic  err
);
  word_t held;
  logic  par_bit;

  par_xcvr_latch #(.WIDTH(WORD_W)) u_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .le   (le),
    .d    (din),
    .q    (held)
  );

  always_comb begin
    par_bit = gen ? make_par(held[DATA_W-1:0], par_odd) : held[DATA_W];
    dout    = {par_bit, held[DATA_W-1:0]};
    err     = bad_word(held, par_odd);
  end
endmodule

// File: rtl/par_xcvr.sv
module par_xcvr
  import par_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_a2b,
  input  logic              oe_n,
  input  logic              par_odd,
  input  logic              le_ab,
  input  logic              le_ba,
  input  logic              gen_ab,
  input  logic              gen_ba,
  input  logic [WORD_W-1:0] a_in,
  output logic [WORD_W-1:0] a_out,
  output logic              a_oe,
  input  logic [WORD_W-1:0] b_in,
  output logic [WORD_W-1:0] b_out,
  output logic              b_oe,
  output logic              err_a,
  output logic              err_b
);
  localparam int unsigned NDIR = 2; // index 0: A to B, 1: B to A

  logic rst_i_n;
  word_t      p_din [NDIR];
  word_t      p_dout[NDIR];
  logic [NDIR-1:0] p_le, p_gen, p_err;

  par_xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  always_comb begin
    p_din[0] = a_in;  p_le[0] = le_ab; p_gen[0] = gen_ab;
    p_din[1] = b_in;  p_le[1] = le_ba; p_gen[1] = gen_ba;
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    par_xcvr_path u_path (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .le     (p_le[g]),
      .gen    (p_gen[g]),
      .par_odd(par_odd),
      .din    (p_din[g]),
      .dout   (p_dout[g]),
      .err    (p_err[g])
    );
  end

  always_comb begin
    b_out = p_dout[0];
    a_out = p_dout[1];
    err_a = p_err[0];
    err_b = p_err[1];
    b_oe  = !oe_n &&  dir_a2b;
    a_oe  = !oe_n && !dir_a2b;
  end
endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk
  import par_xcvr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              dir_a2b,
  input logic              oe_n,
  input logic              par_odd,
  input logic              le_ab,
  input logic              le_ba,
  input logic              gen_ab,
  input logic              gen_ba,
  input logic [WORD_W-1:0] a_in,
  input logic [WORD_W-1:0] a_out,
  input logic              a_oe,
  input logic [WORD_W-1:0] b_in,
  input logic [WORD_W-1:0] b_out,
  input logic              b_oe,
  input logic              err_a,
  input logic              err_b
);
  // R8
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));
  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));
  // R1
  pass_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ab && !gen_ab) |-> (b_out == a_in));
  // R1
  pass_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ba && !gen_ba) |-> (a_out == b_in));
  // R2
  hold_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && $past(!le_ab)) |-> $stable(b_out[DATA_W-1:0]));
  // R2
  hold_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && $past(!le_ba)) |-> $stable(a_out[DATA_W-1:0]));
  // R4
  gen_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ab |-> ((^b_out) == par_odd));
  // R4
  gen_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ba |-> ((^a_out) == par_odd));
  // R6
  err_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_ab |-> (err_a == ((^b_out) ^ par_odd)));
  // R6
  err_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_ba |-> (err_b == ((^a_out) ^ par_odd)));
endmodule

bind par_xcvr par_xcvr_chk u_chk (.*);

// File: tb/par_xcvr_tb.sv
module par_xcvr_tb;
  logic       clk = 1'b0;
  logic       rst_n, dir_a2b, oe_n, par_odd, le_ab, le_ba, gen_ab, gen_ba;
  logic [8:0] a_in, b_in;
  logic [8:0] a_out, b_out;
  logic       a_oe, b_oe, err_a, err_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  par_xcvr u_dut (.*);

  function automatic logic m_par(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
  function automatic logic m_err(input logic [8:0] w, input logic odd);
    return (^w) ^ odd;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; dir_a2b = 1; oe_n = 1; par_odd = 0;
    le_ab = 0; le_ba = 0; gen_ab = 0; gen_ba = 0;
    a_in = 9'h1A5; b_in = 9'h05A;
    repeat (2) @(negedge clk);
    chk("R9 b_out reset", b_out, 9'h0);
    chk("R9 a_out reset", a_out, 9'h0);
    chk("R9 err reset", {7'b0, err_a, err_b}, 9'h0);
    chk("R8 oe off", {7'b0, a_oe, b_oe}, 9'h0);
    rst_n = 1;
    // capture attempt while internal reset still held (first edge)
    le_ab = 1; a_in = 9'h0F3;
    @(negedge clk); le_ab = 0; #1;
    chk("R9 release after two edges", b_out, 9'h0);
    @(negedge clk); le_ab = 1;
    @(negedge clk); le_ab = 0; a_in = 9'h111; #1;
    chk("R9 capture after release", b_out, 9'h0F3);
  endtask

  task automatic t_transparent();
    gen_ab = 0; gen_ba = 0; le_ab = 1; le_ba = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      a_in = 9'(i * 37 + 5); b_in = 9'(i * 91 + 200);
      #1;
      chk("R1 A to B", b_out, a_in);
      chk("R1 B to A", a_out, b_in);
      chk("R5 copy bit8", {8'b0, b_out[8]}, {8'b0, a_in[8]});
    end
  endtask

  task automatic t_hold();
    logic [8:0] keep_ab, keep_ba;
    @(negedge clk); le_ab = 1; le_ba = 1; gen_ab = 0; gen_ba = 0;
    a_in = 9'h16C; b_in = 9'h0D3; keep_ab = a_in; keep_ba = b_in;
    @(negedge clk); le_ab = 0; le_ba = 0;
    a_in = 9'h001; b_in = 9'h1FE; #1;
    chk("R2 hold A to B", b_out, keep_ab);
    chk("R2 hold B to A", a_out, keep_ba);
    // B-to-A activity must not reach b_out
    le_ba = 1;
    repeat (3) begin
      @(negedge clk); b_in = b_in + 9'd7; #1;
      chk("R3 b_out isolated", b_out, keep_ab);
    end
    le_ba = 0; le_ab = 1;
    @(negedge clk); a_in = 9'h0AA; keep_ba = a_out; #1;
    chk("R3 a_out isolated", a_out, keep_ba);
    le_ab = 0;
  endtask

  task automatic t_simul();
    // bad parity from A, generation toward B
    @(negedge clk); le_ab = 1; gen_ab = 1; par_odd = 0;
    a_in = {1'b1, 8'h03}; #1;
    chk("R7 err_a with gen", {8'b0, err_a}, 9'h1);
    chk("R7 gen bit", b_out, {1'b0, 8'h03});
    gen_ab = 0; #1;
    chk("R7 err_a without gen", {8'b0, err_a}, 9'h1);
  endtask

  task automatic t_matrix();
    for (int dir = 0; dir < 2; dir++)
      for (int oe = 0; oe < 2; oe++)
        for (int md = 0; md < 2; md++)
          for (int po = 0; po < 2; po++)
            for (int k = 0; k < 6; k++) begin
              logic [8:0] wa, wb, ea, eb;
              @(negedge clk);
              dir_a2b = dir[0]; oe_n = oe[0]; gen_ab = md[0]; gen_ba = md[0];
              par_odd = po[0]; le_ab = 1; le_ba = 1;
              wa = 9'(k * 83 + dir * 17 + md * 5 + 3);
              wb = 9'(k * 59 + po * 29 + 11);
              a_in = wa; b_in = wb;
              @(negedge clk); le_ab = 0; le_ba = 0;
              a_in = ~wa; b_in = ~wb; #1;
              ea = md[0] ? {m_par(wa[7:0], po[0]), wa[7:0]} : wa;
              eb = md[0] ? {m_par(wb[7:0], po[0]), wb[7:0]} : wb;
              if (md[0]) chk("R4 generate toward B", b_out, ea);
              else       chk("R5 copy toward B", b_out, ea);
              if (md[0]) chk("R4 generate toward A", a_out, eb);
              else       chk("R5 copy toward A", a_out, eb);
              chk("R6 err_a", {8'b0, err_a}, {8'b0, m_err(wa, po[0])});
              chk("R6 err_b", {8'b0, err_b}, {8'b0, m_err(wb, po[0])});
              chk("R8 oe pair", {7'b0, a_oe, b_oe},
                  {7'b0, (oe == 0) && (dir == 0), (oe == 0) && (dir == 1)});
            end
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_simul();
    t_matrix();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule